// File: doc/BRIEF.md
# SPI FIFO Mode and DMA Request Controller

This block sits between a register bus and a serial shift engine. It holds outgoing words for the engine and incoming words for the bus, and at run time it arranges that storage in one of four ways: a queue on both sides, on the receive side only, on the transmit side only, or on neither. A side without a queue becomes a single-entry buffer with no flow control: a newer word replaces the one held there.

It reports empty and full status for both sides, a busy indication, and an interrupt source that is active while the transmit side has room. It drives two DMA request lines with acknowledge inputs. A priority input selects whether a request falls for one cycle after each acknowledge or stays up for as long as its condition holds. When the receive queue is full, the engine is not offered transmit data, so transfers pause until the bus drains a word. In the queue-less mode the transmit request can follow either free buffer space or the end of a transfer.

Top module: `spi_fifo_dma_ctl`

## Requirements
- R1: With cfg_mode = 0 both sides are DEPTH-entry first-in first-out queues that keep word order. A bus write to a full transmit queue is ignored.
- R2: With cfg_mode = 1 the receive side is a DEPTH-entry queue. The transmit side holds one word, and a write to it while it is full replaces that word.
- R3: With cfg_mode = 2 the transmit side is a DEPTH-entry queue, and writes to it while it is full are ignored. The receive side holds one word, and a newer received word replaces it.
- R4: With cfg_mode = 3 both sides hold one word each and a newer word replaces the held one. A bus read of an empty receive side is ignored.
- R5: stat_tx_empty, stat_tx_full, stat_rx_empty and stat_rx_full report the fill state of each side against its capacity for the current mode: DEPTH for a queue, 1 for a single-entry buffer.
- R6: In cfg_mode 0 or 1, while the receive queue is full, eng_tx_avail is 0 even when transmit data is waiting. busy is 1 when eng_active is 1 or eng_tx_avail is 1, and is 0 otherwise.
- R7: With cfg_dma_hold = 0, a request that is acknowledged is low in the cycle after the acknowledge and is then driven from its condition again.
- R8: With cfg_dma_hold = 1, each request equals its condition; acknowledges have no effect on it.
- R9: The receive request condition is a non-empty receive side. The transmit request condition is free transmit space, except as stated in R10.
- R10: In cfg_mode 3 with cfg_txreq_on_free = 0, the transmit request condition is a transfer-complete flag (set by eng_done, cleared by dma_tx_ack or a bus write) together with free transmit space. With cfg_txreq_on_free = 1 it is free space alone.
- R11: txnf_irq is 1 exactly when cfg_txnf_irq_en is 1 and the transmit side is not full.
- R12: After reset both sides are empty, busy is 0 and dma_rx_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Storage arrangement: 0 both queues, 1 receive queue, 2 transmit queue, 3 none |
| cfg_dma_hold | input | 1 | 1: requests follow their condition; 0: drop after acknowledge |
| cfg_txreq_on_free | input | 1 | Mode 3 transmit request source: 1 free space, 0 transfer end |
| cfg_txnf_irq_en | input | 1 | Enables the transmit-not-full interrupt |
| bus_wr | input | 1 | Write a word into the transmit side |
| bus_wdata | input | DATA_W | Word to write |
| bus_rd | input | 1 | Remove the head word of the receive side |
| bus_rdata | output | DATA_W | Head word of the receive side |
| eng_tx_avail | output | 1 | A transmit word is offered to the engine |
| eng_tx_data | output | DATA_W | Offered transmit word |
| eng_tx_take | input | 1 | Engine takes the offered word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_active | input | 1 | Engine is shifting a word |
| eng_done | input | 1 | Single-cycle pulse at the end of a transfer |
| stat_tx_empty | output | 1 | Transmit side empty |
| stat_tx_full | output | 1 | Transmit side full |
| stat_rx_empty | output | 1 | Receive side empty |
| stat_rx_full | output | 1 | Receive side full |
| busy | output | 1 | Transfer in progress or about to start |
| txnf_irq | output | 1 | Transmit-not-full interrupt source |
| dma_tx_req | output | 1 | DMA transmit request |
| dma_tx_ack | input | 1 | DMA transmit acknowledge |
| dma_rx_req | output | 1 | DMA receive request |
| dma_rx_ack | input | 1 | DMA receive acknowledge |

## Verification
The bench builds the block with its defaults, 32-bit words and a depth of 4. With that depth, five writes in a row overrun every arrangement: a queue shows both the discarded fifth word and the kept order of the first four, while a single-entry side shows that only the fifth word is left. A depth of 4 also fills the receive queue in four pushes, so the transfer pause and its release, and a hold-mode request that drains to empty, each take only a few cycles to reach.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    typedef enum logic [1:0] {
        FM_BIDIR   = 2'd0,
        FM_RX_ONLY = 2'd1,
        FM_TX_ONLY = 2'd2,
        FM_LEGACY  = 2'd3
    } fifo_mode_e;

    function automatic logic tx_queued(input fifo_mode_e m);
        return (m == FM_BIDIR) || (m == FM_TX_ONLY);
    endfunction

    function automatic logic rx_queued(input fifo_mode_e m);
        return (m == FM_BIDIR) || (m == FM_RX_ONLY);
    endfunction

endpackage

// File: rtl/sfd_buf.sv
module sfd_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         single,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt, cap;
    logic          do_pop, do_push, overwrite;

    assign cap       = single ? CW'(1) : CAP_Q;
    assign empty     = (cnt == '0);
    assign full      = (cnt >= cap);
    assign do_pop    = pop & ~empty;
    assign do_push   = push & (~full | do_pop);
    assign overwrite = push & single & full & ~do_pop;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)   mem[wr_ptr] <= push_data;
        if (overwrite) mem[rd_ptr] <= push_data;
    end
endmodule

// File: rtl/sfd_dreq.sv
module sfd_dreq (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic cond,
    input  logic ack,
    output logic req
);
    logic gap_q;

    always_ff @(posedge clk) begin
        if (rst) gap_q <= 1'b0;
        else     gap_q <= ack & req & ~hold;
    end

    assign req = cond & ~(gap_q & ~hold);
endmodule

// File: rtl/spi_fifo_dma_ctl.sv
module spi_fifo_dma_ctl
    import sfd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_dma_hold,
    input  logic              cfg_txreq_on_free,
    input  logic              cfg_txnf_irq_en,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_tx_avail,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_take,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_active,
    input  logic              eng_done,
    output logic              stat_tx_empty,
    output logic              stat_tx_full,
    output logic              stat_rx_empty,
    output logic              stat_rx_full,
    output logic              busy,
    output logic              txnf_irq,
    output logic              dma_tx_req,
    input  logic              dma_tx_ack,
    output logic              dma_rx_req,
    input  logic              dma_rx_ack
);
    fifo_mode_e mode;
    logic       suspend, xfer_done_q, tx_cond;

    assign mode = fifo_mode_e'(cfg_mode);

    sfd_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_txbuf (
        .clk       (clk),
        .rst       (rst),
        .single    (~tx_queued(mode)),
        .push      (bus_wr),
        .push_data (bus_wdata),
        .pop       (eng_tx_take & eng_tx_avail),
        .head      (eng_tx_data),
        .empty     (stat_tx_empty),
        .full      (stat_tx_full)
    );

    sfd_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_rxbuf (
        .clk       (clk),
        .rst       (rst),
        .single    (~rx_queued(mode)),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (bus_rd),
        .head      (bus_rdata),
        .empty     (stat_rx_empty),
        .full      (stat_rx_full)
    );

    // pause when the receive queue has no room for the word a transfer returns
    assign suspend      = rx_queued(mode) & stat_rx_full;
    assign eng_tx_avail = ~stat_tx_empty & ~suspend;
    assign busy         = eng_active | eng_tx_avail;
    assign txnf_irq     = cfg_txnf_irq_en & ~stat_tx_full;

    always_ff @(posedge clk) begin
        if (rst)                       xfer_done_q <= 1'b0;
        else if (dma_tx_ack || bus_wr) xfer_done_q <= 1'b0;
        else if (eng_done)             xfer_done_q <= 1'b1;
    end

    assign tx_cond = (mode == FM_LEGACY && !cfg_txreq_on_free)
                   ? (xfer_done_q & ~stat_tx_full)
                   : ~stat_tx_full;

    sfd_dreq u_txreq (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg_dma_hold),
        .cond (tx_cond),
        .ack  (dma_tx_ack),
        .req  (dma_tx_req)
    );

    sfd_dreq u_rxreq (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg_dma_hold),
        .cond (~stat_rx_empty),
        .ack  (dma_rx_ack),
        .req  (dma_rx_req)
    );
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic       cfg_dma_hold,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       eng_tx_avail,
    input logic       eng_tx_take,
    input logic       eng_rx_push,
    input logic       stat_tx_full,
    input logic       stat_rx_empty,
    input logic       stat_rx_full,
    input logic       dma_rx_req,
    input logic       dma_rx_ack
);
    logic rxq, txq;
    assign rxq = (cfg_mode == 2'd0) || (cfg_mode == 2'd1);
    assign txq = (cfg_mode == 2'd0) || (cfg_mode == 2'd2);

    a_r6_suspend: assert property (@(posedge clk) disable iff (rst)
        (rxq && stat_rx_full) |-> !eng_tx_avail);

    a_r7_gap_after_ack: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dma_hold && dma_rx_ack && dma_rx_req) |=> !dma_rx_req);

    a_r8_hold_follows: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_hold && !stat_rx_empty) |-> dma_rx_req);

    a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (txq && $stable(cfg_mode) && stat_tx_full && bus_wr && !eng_tx_take)
        |=> stat_tx_full);

    a_r4_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
        (stat_rx_empty && bus_rd && !eng_rx_push) |=> stat_rx_empty);
endmodule

bind spi_fifo_dma_ctl sfd_checker u_chk (.*);

// File: tb/spi_fifo_dma_ctl_tb.sv
module spi_fifo_dma_ctl_tb;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_dma_hold = 1'b0, cfg_txreq_on_free = 1'b1, cfg_txnf_irq_en = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0, eng_rx_data = '0;
    logic [DW-1:0] bus_rdata, eng_tx_data;
    logic eng_tx_avail, eng_tx_take = 1'b0, eng_rx_push = 1'b0;
    logic eng_active = 1'b0, eng_done = 1'b0;
    logic stat_tx_empty, stat_tx_full, stat_rx_empty, stat_rx_full;
    logic busy, txnf_irq, dma_tx_req, dma_rx_req;
    logic dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_fifo_dma_ctl u_dut (.*);

    // fields: mode[7:6], tx capacity[5:3], rx capacity[2:0]
    localparam logic [7:0] VEC [4] = '{
        {2'd0, 3'd4, 3'd4},
        {2'd1, 3'd1, 3'd4},
        {2'd2, 3'd4, 3'd1},
        {2'd3, 3'd1, 3'd1}
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_wdata = d; tick(); bus_wr = 1'b0;
    endtask

    task automatic rxpush(input logic [DW-1:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d; tick(); eng_rx_push = 1'b0;
    endtask

    initial begin
        tick();
        do_reset();
        // R12 reset state
        check("R12 tx_empty", DW'(stat_tx_empty), 1);
        check("R12 rx_empty", DW'(stat_rx_empty), 1);
        check("R12 busy", DW'(busy), 0);
        check("R12 rx_req", DW'(dma_rx_req), 0);
        check("R9 tx_req free space", DW'(dma_tx_req), 1);

        // table walk: capacity, overrun and order for each mode (R1..R5)
        for (int i = 0; i < 4; i++) begin
            int txcap, rxcap, n;
            logic [DW-1:0] base;
            cfg_mode = VEC[i][7:6];
            txcap = int'(VEC[i][5:3]);
            rxcap = int'(VEC[i][2:0]);
            base = 32'hA000_0000 + 32'(i * 256);
            do_reset();
            for (int k = 0; k < 5; k++) wr(base + 32'(k));
            check($sformatf("R5 tx_full mode%0d", i), DW'(stat_tx_full), 1);
            n = 0;
            while (eng_tx_avail && n < 6) begin
                check($sformatf("R1 R2 R3 R4 tx word mode%0d", i), eng_tx_data,
                      (txcap == 1) ? base + 32'd4 : base + 32'(n));
                eng_tx_take = 1'b1; tick(); eng_tx_take = 1'b0;
                n++;
            end
            check($sformatf("R5 tx capacity mode%0d", i), DW'(n), DW'(txcap));
            check($sformatf("R5 tx_empty mode%0d", i), DW'(stat_tx_empty), 1);
            for (int k = 0; k < 5; k++) rxpush(base + 32'h80 + 32'(k));
            check($sformatf("R5 rx_full mode%0d", i), DW'(stat_rx_full), 1);
            n = 0;
            while (!stat_rx_empty && n < 6) begin
                check($sformatf("R1 R2 R3 R4 rx word mode%0d", i), bus_rdata,
                      (rxcap == 1) ? base + 32'h84 : base + 32'h80 + 32'(n));
                bus_rd = 1'b1; tick(); bus_rd = 1'b0;
                n++;
            end
            check($sformatf("R5 rx capacity mode%0d", i), DW'(n), DW'(rxcap));
        end

        // R4: read of empty receive side ignored, then one push still reads back
        cfg_mode = 2'd3; do_reset();
        bus_rd = 1'b1; tick(); bus_rd = 1'b0;
        check("R4 empty read keeps empty", DW'(stat_rx_empty), 1);
        rxpush(32'h1234_5678);
        check("R4 word after empty read", bus_rdata, 32'h1234_5678);

        // R6: suspend in mode 0
        cfg_mode = 2'd0; do_reset();
        wr(32'h11);
        check("R6 busy with data", DW'(busy), 1);
        for (int k = 0; k < 4; k++) rxpush(32'h20 + 32'(k));
        check("R6 suspended avail", DW'(eng_tx_avail), 0);
        check("R6 suspended busy", DW'(busy), 0);
        eng_active = 1'b1; tick();
        check("R6 busy from engine", DW'(busy), 1);
        eng_active = 1'b0;
        bus_rd = 1'b1; tick(); bus_rd = 1'b0;
        check("R6 resumed avail", DW'(eng_tx_avail), 1);
        // no suspend in mode 2 (single receive entry)
        cfg_mode = 2'd2; do_reset();
        wr(32'h11); rxpush(32'h22);
        check("R6 mode2 full rx no pause", DW'(eng_tx_avail), 1);

        // R7 low priority receive request
        cfg_mode = 2'd0; cfg_dma_hold = 1'b0; do_reset();
        rxpush(32'h1); rxpush(32'h2);
        check("R9 rx_req non-empty", DW'(dma_rx_req), 1);
        bus_rd = 1'b1; dma_rx_ack = 1'b1; tick(); bus_rd = 1'b0; dma_rx_ack = 1'b0;
        check("R7 low after ack", DW'(dma_rx_req), 0);
        tick();
        check("R7 rises again", DW'(dma_rx_req), 1);

        // R8 hold
        cfg_dma_hold = 1'b1;
        dma_rx_ack = 1'b1; tick(); dma_rx_ack = 1'b0;
        check("R8 ack no effect", DW'(dma_rx_req), 1);
        bus_rd = 1'b1; dma_rx_ack = 1'b1; tick(); bus_rd = 1'b0; dma_rx_ack = 1'b0;
        check("R8 drops at empty", DW'(dma_rx_req), 0);
        cfg_dma_hold = 1'b0;

        // R10 mode 3 transfer-end transmit request
        cfg_mode = 2'd3; cfg_txreq_on_free = 1'b0; do_reset();
        check("R10 no req before done", DW'(dma_tx_req), 0);
        eng_done = 1'b1; tick(); eng_done = 1'b0;
        check("R10 req after done", DW'(dma_tx_req), 1);
        dma_tx_ack = 1'b1; tick(); dma_tx_ack = 1'b0;
        check("R10 cleared by ack", DW'(dma_tx_req), 0);
        tick();
        check("R10 stays clear", DW'(dma_tx_req), 0);
        cfg_txreq_on_free = 1'b1; tick();
        check("R10 on-free selects space", DW'(dma_tx_req), 1);

        // R11 interrupt
        cfg_mode = 2'd0; cfg_txnf_irq_en = 1'b1; do_reset();
        check("R11 irq not full", DW'(txnf_irq), 1);
        for (int k = 0; k < 4; k++) wr(32'(k));
        check("R11 irq full", DW'(txnf_irq), 0);
        check("R9 tx_req full", DW'(dma_tx_req), 0);
        cfg_txnf_irq_en = 1'b0;
        eng_tx_take = 1'b1; tick(); eng_tx_take = 1'b0;
        check("R11 irq disabled", DW'(txnf_irq), 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule